// File: doc/BRIEF.md
# DRAM Idle Low-Power State Controller

This block watches a bus-busy strobe on the memory controller clock, which runs at half the DRAM clock rate. It counts consecutive idle cycles of that clock and steps the memory subsystem into deeper low-power states as the count crosses each programmed threshold.

There are five states: power-down, self-refresh, self-refresh with the controller clock gated, self-refresh power-down (LPDDR4 only) and standby. Standby gates the controller, PHY and DRAM clocks. Every transition waits for an acknowledge. Any bus activity starts a wake-up sequence: the clocks are ungated first, the request is dropped next, and the block returns to the active state once the exit acknowledge arrives.

Top module: `dram_idle_pm`

## Requirements
- R1: The idle count equals the number of consecutive clock edges at which `bus_busy` was sampled low. When the count reaches `pd_thr` (a plain cycle count), the next edge raises `pd_req` and sets `lp_state` to 1.
- R2: When the count reaches `sr_thr` × 2^SCALE_SH (1024 by default), the block requests self-refresh: `sr_req` is high and `lp_state` is 2.
- R3: When the count reaches `srg_thr` × 2^SCALE_SH, `lp_state` becomes 3 with `sr_req` high. `ctrl_clk_en` goes low only after that entry has been acknowledged.
- R4: When `mem_is_lp4` is high and the count reaches `srpd_thr` × 2^SCALE_SH, `lp_state` becomes 4 with `srpd_req` high. When `mem_is_lp4` is low, this state is never chosen.
- R5: When the count reaches `stby_thr` (a plain cycle count), `lp_state` becomes 5 and `sr_req` is raised first. `ctrl_clk_en`, `phy_clk_en` and `dram_clk_en` drop only after `entry_ack`.
- R6: A threshold of zero disables its state.
- R7: When several thresholds are met, the deepest eligible state is chosen. The depth order is the `lp_state` code order 1 < 2 < 3 < 4 < 5. The block moves deeper only after `entry_ack` for the current state has been received, and at most one of `pd_req`, `sr_req` and `srpd_req` is high at any time.
- R8: Bus activity in a low-power state ungates all clocks one cycle before the request is dropped. `lp_state` returns to 0 on the edge that samples `exit_ack`.
- R9: The idle count saturates rather than wrapping, so an idle period longer than the counter range still reaches the deepest programmed state.
- R10: A busy cycle clears the idle count, so idle bursts shorter than every threshold never leave state 0.
- R11: After reset, `lp_state` is 0, no request is raised and all clock enables are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller-side clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_busy | input | 1 | High in any cycle with bus activity |
| mem_is_lp4 | input | 1 | Memory type is LPDDR4 |
| pd_thr | input | THR_W | Power-down idle threshold, in cycles |
| sr_thr | input | THR_W | Self-refresh threshold, in units of 2^SCALE_SH cycles |
| srg_thr | input | THR_W | Self-refresh plus controller clock gate threshold, in scaled units |
| srpd_thr | input | THR_W | Self-refresh power-down threshold, in scaled units |
| stby_thr | input | THR_W | Standby threshold, in cycles |
| entry_ack | input | 1 | Acknowledge of the current state entry |
| exit_ack | input | 1 | Acknowledge of the exit |
| lp_state | output | 3 | 0 active, 1 PD, 2 SR, 3 SR+gate, 4 SRPD, 5 standby |
| pd_req | output | 1 | Power-down request |
| sr_req | output | 1 | Self-refresh request |
| srpd_req | output | 1 | Self-refresh power-down request |
| ctrl_clk_en | output | 1 | Controller clock enable |
| phy_clk_en | output | 1 | PHY clock enable |
| dram_clk_en | output | 1 | DRAM clock enable |

## Verification
The bench withholds `entry_ack` while higher thresholds are crossed. A design that deepens early would change state before the acknowledge arrives. It then holds the block idle for longer than the counter range before acknowledging. A counter that wraps would leave the block stuck in power-down instead of moving on to self-refresh. The exit is stepped one cycle at a time to catch a request dropped while its clocks are still gated. The self-refresh power-down threshold is run with both memory types, which exposes a design that ignores the type select.

// File: rtl/dram_idle_pm.sv
module dram_idle_pm #(
  parameter int THR_W    = 16,
  parameter int SCALE_SH = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_busy,
  input  logic             mem_is_lp4,
  input  logic [THR_W-1:0] pd_thr,
  input  logic [THR_W-1:0] sr_thr,
  input  logic [THR_W-1:0] srg_thr,
  input  logic [THR_W-1:0] srpd_thr,
  input  logic [THR_W-1:0] stby_thr,
  input  logic             entry_ack,
  input  logic             exit_ack,
  output logic [2:0]       lp_state,
  output logic             pd_req,
  output logic             sr_req,
  output logic             srpd_req,
  output logic             ctrl_clk_en,
  output logic             phy_clk_en,
  output logic             dram_clk_en
);
  localparam int CNT_W = THR_W + SCALE_SH;
  localparam logic [2:0] ST_ACT = 3'd0, ST_PD = 3'd1, ST_SR = 3'd2,
                         ST_SRG = 3'd3, ST_SRPD = 3'd4, ST_STBY = 3'd5;
  localparam logic [1:0] PH_SET = 2'd0, PH_ENT = 2'd1, PH_UNG = 2'd2, PH_EXT = 2'd3;

  logic [CNT_W-1:0] idle_cnt;
  logic [2:0]       cur, tgt;
  logic [1:0]       ph;
  logic             wake;
  logic             pd_hit, sr_hit, srg_hit, srpd_hit, stby_hit;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)              idle_cnt <= '0;
    else if (bus_busy)       idle_cnt <= '0;
    else if (idle_cnt != '1) idle_cnt <= idle_cnt + 1'b1;

  assign pd_hit   = (|pd_thr)   && idle_cnt >= {{SCALE_SH{1'b0}}, pd_thr};
  assign stby_hit = (|stby_thr) && idle_cnt >= {{SCALE_SH{1'b0}}, stby_thr};
  assign sr_hit   = (|sr_thr)   && idle_cnt >= {sr_thr, {SCALE_SH{1'b0}}};
  assign srg_hit  = (|srg_thr)  && idle_cnt >= {srg_thr, {SCALE_SH{1'b0}}};
  assign srpd_hit = mem_is_lp4 && (|srpd_thr) && idle_cnt >= {srpd_thr, {SCALE_SH{1'b0}}};

  always_comb begin
    if (stby_hit)      tgt = ST_STBY;
    else if (srpd_hit) tgt = ST_SRPD;
    else if (srg_hit)  tgt = ST_SRG;
    else if (sr_hit)   tgt = ST_SR;
    else if (pd_hit)   tgt = ST_PD;
    else               tgt = ST_ACT;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cur  <= ST_ACT;
      ph   <= PH_SET;
      wake <= 1'b0;
    end else begin
      if (bus_busy && cur != ST_ACT) wake <= 1'b1;
      case (ph)
        PH_SET:
          if (cur != ST_ACT && (wake || bus_busy)) ph <= PH_UNG;
          else if (!bus_busy && tgt > cur) begin
            cur <= tgt;
            ph  <= PH_ENT;
          end
        PH_ENT: if (entry_ack) ph <= PH_SET;
        PH_UNG: ph <= PH_EXT;
        default:
          if (exit_ack) begin
            cur  <= ST_ACT;
            ph   <= PH_SET;
            wake <= 1'b0;
          end
      endcase
    end

  logic req_on, gated;
  assign req_on      = ph != PH_EXT;
  assign gated       = ph == PH_SET;
  assign lp_state    = cur;
  assign pd_req      = req_on && cur == ST_PD;
  assign sr_req      = req_on && (cur == ST_SR || cur == ST_SRG || cur == ST_STBY);
  assign srpd_req    = req_on && cur == ST_SRPD;
  assign ctrl_clk_en = !(gated && (cur == ST_SRG || cur == ST_STBY));
  assign phy_clk_en  = !(gated && cur == ST_STBY);
  assign dram_clk_en = !(gated && cur == ST_STBY);
endmodule

module dram_idle_pm_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       mem_is_lp4,
  input logic       pd_req,
  input logic       sr_req,
  input logic       srpd_req,
  input logic       ctrl_clk_en,
  input logic       phy_clk_en,
  input logic       dram_clk_en
);
  // R7
  req_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pd_req, sr_req, srpd_req}));
  // R4
  srpd_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(srpd_req) |-> $past(mem_is_lp4));
  // R3
  ctrl_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_clk_en |-> sr_req);
  // R5
  dram_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dram_clk_en || !phy_clk_en) |-> (sr_req && !ctrl_clk_en));
  // R8
  exit_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sr_req) && !srpd_req) |-> $past(ctrl_clk_en && phy_clk_en && dram_clk_en));
endmodule

bind dram_idle_pm dram_idle_pm_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mem_is_lp4(mem_is_lp4),
  .pd_req(pd_req), .sr_req(sr_req), .srpd_req(srpd_req),
  .ctrl_clk_en(ctrl_clk_en), .phy_clk_en(phy_clk_en), .dram_clk_en(dram_clk_en)
);

// File: tb/test_dram_idle_pm.sv
module test_dram_idle_pm;
  localparam int TW = 6;
  localparam int SAT = 65535;

  logic clk = 0, rst_n = 0, bus_busy = 1, mem_is_lp4 = 0, entry_ack = 1, exit_ack = 1;
  logic [TW-1:0] pd_thr = 0, sr_thr = 0, srg_thr = 0, srpd_thr = 0, stby_thr = 0;
  logic [2:0] lp_state;
  logic pd_req, sr_req, srpd_req, ctrl_clk_en, phy_clk_en, dram_clk_en;
  int checks = 0, fails = 0;
  int m_idle, m_cur, m_ph;
  bit m_wake;

  always #2 clk = ~clk;

  dram_idle_pm #(.THR_W(TW), .SCALE_SH(10)) i_dram_idle_pm (
    .clk(clk), .rst_n(rst_n), .bus_busy(bus_busy), .mem_is_lp4(mem_is_lp4),
    .pd_thr(pd_thr), .sr_thr(sr_thr), .srg_thr(srg_thr), .srpd_thr(srpd_thr),
    .stby_thr(stby_thr), .entry_ack(entry_ack), .exit_ack(exit_ack),
    .lp_state(lp_state), .pd_req(pd_req), .sr_req(sr_req), .srpd_req(srpd_req),
    .ctrl_clk_en(ctrl_clk_en), .phy_clk_en(phy_clk_en), .dram_clk_en(dram_clk_en));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model: state codes 0..5, phases 0 settled 1 entering 2 ungating 3 exiting
  always @(posedge clk) begin
    int t;
    if (!rst_n) begin
      m_idle = 0; m_cur = 0; m_ph = 0; m_wake = 0;
    end else begin
      t = 0;
      if (pd_thr != 0 && m_idle >= int'(pd_thr)) t = 1;
      if (sr_thr != 0 && m_idle >= int'(sr_thr) * 1024) t = 2;
      if (srg_thr != 0 && m_idle >= int'(srg_thr) * 1024) t = 3;
      if (mem_is_lp4 && srpd_thr != 0 && m_idle >= int'(srpd_thr) * 1024) t = 4;
      if (stby_thr != 0 && m_idle >= int'(stby_thr)) t = 5;
      if (m_ph == 0) begin
        if (m_cur != 0 && (m_wake || bus_busy)) m_ph = 2;
        else if (!bus_busy && t > m_cur) begin m_cur = t; m_ph = 1; end
        if (bus_busy && m_cur != 0) m_wake = 1;
      end else if (m_ph == 1) begin
        if (bus_busy) m_wake = 1;
        if (entry_ack) m_ph = 0;
      end else if (m_ph == 2) begin
        if (bus_busy) m_wake = 1;
        m_ph = 3;
      end else if (exit_ack) begin
        m_cur = 0; m_ph = 0; m_wake = 0;
      end else if (bus_busy) m_wake = 1;
      m_idle = bus_busy ? 0 : (m_idle < SAT ? m_idle + 1 : SAT);
    end
  end

  always @(negedge clk) if (rst_n) begin
    bit on, g;
    on = m_ph != 3;
    g = m_ph == 0;
    check(lp_state == 3'(m_cur), "R7 lp_state", lp_state, m_cur);
    check(pd_req == (on && m_cur == 1), "R1 pd_req", pd_req, on && m_cur == 1);
    check(sr_req == (on && (m_cur == 2 || m_cur == 3 || m_cur == 5)), "R2 sr_req", sr_req,
          on && (m_cur == 2 || m_cur == 3 || m_cur == 5));
    check(srpd_req == (on && m_cur == 4), "R4 srpd_req", srpd_req, on && m_cur == 4);
    check(ctrl_clk_en == !(g && (m_cur == 3 || m_cur == 5)), "R3 ctrl_clk_en", ctrl_clk_en,
          !(g && (m_cur == 3 || m_cur == 5)));
    check(phy_clk_en == !(g && m_cur == 5), "R5 phy_clk_en", phy_clk_en, !(g && m_cur == 5));
    check(dram_clk_en == !(g && m_cur == 5), "R5 dram_clk_en", dram_clk_en, !(g && m_cur == 5));
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic to_active();
    bus_busy = 1; entry_ack = 1; exit_ack = 1;
    cyc(6);
    pd_thr = 0; sr_thr = 0; srg_thr = 0; srpd_thr = 0; stby_thr = 0; mem_is_lp4 = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    cyc(3);
    rst_n = 1;
    cyc(1);
    // R11
    check(lp_state == 0 && !pd_req && !sr_req && !srpd_req, "R11 reset state", lp_state, 0);
    check(ctrl_clk_en && phy_clk_en && dram_clk_en, "R11 reset clocks", ctrl_clk_en, 1);

    // R1
    pd_thr = 5; bus_busy = 0;
    cyc(20);
    check(pd_req == 1 && lp_state == 1, "R1 pd entry", lp_state, 1);
    bus_busy = 1;
    cyc(6);
    check(lp_state == 0 && !pd_req, "R8 pd exit", lp_state, 0);

    // R10
    pd_thr = 10;
    for (int i = 0; i < 12; i++) begin
      bus_busy = 0; cyc(8);
      check(lp_state == 0, "R10 short idle", lp_state, 0);
      bus_busy = 1; cyc(1);
    end
    to_active();

    // R2 and R7 deepest
    pd_thr = 5; sr_thr = 1; bus_busy = 0;
    cyc(1100);
    check(lp_state == 2 && sr_req && !pd_req, "R2 sr entry", lp_state, 2);
    to_active();

    // R3
    srg_thr = 2; bus_busy = 0;
    cyc(2200);
    check(lp_state == 3 && !ctrl_clk_en && phy_clk_en, "R3 ctrl gated", lp_state, 3);
    to_active();

    // R4
    srg_thr = 2; srpd_thr = 3; mem_is_lp4 = 0; bus_busy = 0;
    cyc(3300);
    check(lp_state == 3 && !srpd_req, "R4 not lp4", lp_state, 3);
    to_active();
    srg_thr = 2; srpd_thr = 3; mem_is_lp4 = 1; bus_busy = 0;
    cyc(3300);
    check(lp_state == 4 && srpd_req && !sr_req, "R4 lp4", lp_state, 4);
    to_active();

    // R6
    bus_busy = 0;
    cyc(3000);
    check(lp_state == 0 && ctrl_clk_en, "R6 all disabled", lp_state, 0);
    to_active();

    // R5 ordering
    stby_thr = 40; entry_ack = 0; exit_ack = 0; bus_busy = 0;
    cyc(50);
    check(lp_state == 5 && sr_req, "R5 sr first", lp_state, 5);
    check(dram_clk_en && phy_clk_en && ctrl_clk_en, "R5 clocks before ack", dram_clk_en, 1);
    entry_ack = 1;
    cyc(2);
    check(!dram_clk_en && !phy_clk_en && !ctrl_clk_en, "R5 clocks gated", dram_clk_en, 0);

    // R8 exit sequence
    bus_busy = 1;
    cyc(1);
    bus_busy = 0;
    check(ctrl_clk_en && phy_clk_en && dram_clk_en && sr_req, "R8 ungate first", sr_req, 1);
    cyc(1);
    check(!sr_req && lp_state == 5, "R8 req dropped", sr_req, 0);
    cyc(3);
    check(lp_state == 5, "R8 wait exit ack", lp_state, 5);
    exit_ack = 1;
    cyc(1);
    check(lp_state == 0, "R8 back active", lp_state, 0);
    to_active();

    // R7 deepen only after ack
    pd_thr = 2; sr_thr = 1; entry_ack = 0; bus_busy = 0;
    cyc(1500);
    check(lp_state == 1, "R7 held until ack", lp_state, 1);
    entry_ack = 1;
    cyc(4);
    check(lp_state == 2, "R7 deepen after ack", lp_state, 2);
    to_active();

    // R9 saturation
    pd_thr = 1; sr_thr = 63; entry_ack = 0; bus_busy = 0;
    cyc(66000);
    check(lp_state == 1, "R9 held pd", lp_state, 1);
    entry_ack = 1;
    cyc(4);
    check(lp_state == 2, "R9 saturated count", lp_state, 2);
    to_active();

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule